// File: doc/BRIEF.md
# Embedded Timer Unit with Escalating Watchdog

This block gathers three tick-driven timers behind a small register port: a periodic timer, a programmable countdown timer and a watchdog. Every timer advances only in clock cycles where the timebase tick input is high, so the tick rate is set entirely by whatever drives that input. Software programs the unit through a control register, observes and acknowledges events through a status register whose event bits clear when written with one, and loads the countdown through an interval register.

The periodic timer raises an event after a power-of-two number of ticks chosen by a 2-bit field. The countdown timer runs from a software value and either stops or reloads at zero. The watchdog escalates on successive expiries that software has not acknowledged: the first only records a warning, the second records a second stage and may interrupt, and the third records the configured reset kind and pulses one of three reset request outputs.

Top module: `etimer_unit`

## Requirements
- R1: After reset, reading addresses 0, 1 and 2 returns zero and every interrupt and reset request output is low.
- R2: The periodic timer sets status bit 26 on the tick that completes 2^(FIT_EXP0 + FIT_EXP_STEP*S) ticks since its last expiry, where S is control bits 25:24; a counter already past a newly selected shorter period expires on the next tick.
- R3: irq_fixed is status bit 26 AND control bit 23, irq_interval is status bit 27 AND control bit 26, and irq_wdog is status bit 30 AND control bit 27.
- R4: A write to address 1 clears every status bit among 31:26 written with one; an event setting a bit in the same cycle wins over the clear.
- R5: A write to address 2 stores the value as reload value and current count; the countdown runs only while control bit 26 is set and the stored value exceeds 1, and expires on the tick that takes it from 1, setting status bit 27. Reading address 2 returns the current count.
- R6: At expiry the countdown reloads its stored value when control bit 22 is set; otherwise it stops with a count of zero until the next write to address 2.
- R7: While control bit 26 is clear the countdown holds its count, and resumes from it when the bit is set again.
- R8: The watchdog expires on the tick that completes 2^(WDT_EXP0 + WDT_EXP_STEP*W) ticks, where W is control bits 31:30, and then restarts.
- R9: A watchdog expiry with status bit 31 clear sets bit 31; with bit 31 set and bit 30 clear it sets bit 30.
- R10: A watchdog expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28 and pulses for one cycle rst_core_req (01), rst_chip_req (10) or rst_sys_req (11), none for 00; the watchdog then stays halted until status bit 31 or 30 is cleared.
- R11: Control bits 31:22 are writable and bits 21:0 read as zero; address 3 reads zero and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tb_tick | input | 1 | Timebase tick enable, one tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 interval, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_fixed | output | 1 | Periodic timer interrupt |
| irq_interval | output | 1 | Countdown timer interrupt |
| irq_wdog | output | 1 | Watchdog second-stage interrupt |
| rst_core_req | output | 1 | One-cycle core reset request |
| rst_chip_req | output | 1 | One-cycle chip reset request |
| rst_sys_req | output | 1 | One-cycle system reset request |

## Verification
The embedded properties assume that reset is applied before the first tick and that register writes and ticks are plain synchronous inputs sampled at the rising edge, with no other constraint on their mix; in particular a status clear may coincide with an expiry, and an interval load may coincide with a countdown expiry. The stimulus drives every input on the falling edge, so these assumptions hold, and it deliberately steers into those same-cycle collisions, into period changes while a counter is already past the new limit, and into all four watchdog reset kinds with the watchdog left unacknowledged.

// File: rtl/etu_pkg.sv
package etu_pkg;
  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IVAL = 2'd2;

  // Writable control bits and clearable status bits
  localparam logic [31:0] CTRL_MASK = 32'hFFC0_0000;
  localparam logic [31:0] STAT_MASK = 32'hFC00_0000;

  // Control bit positions
  localparam int C_WD_PER_LO  = 30;
  localparam int C_WD_KIND_LO = 28;
  localparam int C_WD_IE      = 27;
  localparam int C_IV_EN      = 26;
  localparam int C_FX_PER_LO  = 24;
  localparam int C_FX_IE      = 23;
  localparam int C_IV_AUTO    = 22;

  // Status bit positions
  localparam int S_WD_FIRST   = 31;
  localparam int S_WD_SECOND  = 30;
  localparam int S_WD_KIND_LO = 28;
  localparam int S_IV_EVT     = 27;
  localparam int S_FX_EVT     = 26;

  localparam int N_RST_KINDS  = 3;
endpackage

// File: rtl/etu_period_timer.sv
module etu_period_timer #(
  parameter int EXP0 = 9,
  parameter int STEP = 4,
  localparam int CW  = EXP0 + 3 * STEP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic [1:0] sel,
  output logic       expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   limit;
  logic [CW:0]   one_w;
  int            shamt;

  always_comb begin
    one_w  = (CW+1)'(1);
    shamt  = EXP0 + STEP * int'(sel);
    limit  = (one_w << shamt) - one_w;
    expire = tick && !hold && ({1'b0, cnt_q} >= limit);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (hold)        cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Without a tick the count may only move when forced to rest (R2, R8)
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(cnt_q));
endmodule

// File: rtl/etu_interval_timer.sv
module etu_interval_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         enable,
  input  logic         autoreload,
  output logic         expire,
  output logic [W-1:0] count
);
  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         active;

  always_comb begin
    active = run_q && enable && (reload_q > W'(1));
    expire = tick && active && (cnt_q == W'(1)) && !load;
  end

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    run_d    = run_q;
    if (load) begin
      reload_d = load_val;
      cnt_d    = load_val;
      run_d    = (load_val > W'(1));
    end else if (tick && active) begin
      if (cnt_q == W'(1)) begin
        if (autoreload) begin
          cnt_d = reload_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      run_q    <= run_d;
    end
  end

  assign count = cnt_q;

  p_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(cnt_q));

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !autoreload) |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/etu_wdog_ctl.sv
module etu_wdog_ctl
  import etu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   expire,
  input  logic                   stage1,
  input  logic                   stage2,
  input  logic [1:0]             rst_kind,
  output logic                   set_stage1,
  output logic                   set_stage2,
  output logic                   final_exp,
  output logic                   hold,
  output logic [N_RST_KINDS-1:0] rst_req
);
  logic                   hold_q, hold_d;
  logic [N_RST_KINDS-1:0] rst_q, rst_d;

  always_comb begin
    set_stage1 = expire && !stage1;
    set_stage2 = expire && stage1 && !stage2;
    final_exp  = expire && stage1 && stage2;
    hold_d     = final_exp || (hold_q && stage1 && stage2);
  end

  for (genvar k = 0; k < N_RST_KINDS; k++) begin : g_kind
    assign rst_d[k] = final_exp && (rst_kind == 2'(k + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rst_q  <= '0;
    end else begin
      hold_q <= hold_d;
      rst_q  <= rst_d;
    end
  end

  assign hold    = hold_q;
  assign rst_req = rst_q;

  p_rst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_q) |=> (rst_q == '0));

  p_rst_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_q));
endmodule

// File: rtl/etimer_unit.sv
module etimer_unit
  import etu_pkg::*;
#(
  parameter int FIT_EXP0     = 9,
  parameter int FIT_EXP_STEP = 4,
  parameter int WDT_EXP0     = 17,
  parameter int WDT_EXP_STEP = 4,
  parameter int PIT_W        = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tb_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_fixed,
  output logic        irq_interval,
  output logic        irq_wdog,
  output logic        rst_core_req,
  output logic        rst_chip_req,
  output logic        rst_sys_req
);
  logic [31:0] ctrl_q, ctrl_d;
  logic [31:0] stat_q, stat_d;
  logic        fx_exp, wd_exp, iv_exp;
  logic        wd_set1, wd_set2, wd_final, wd_hold;
  logic [N_RST_KINDS-1:0] wd_rst;
  logic [PIT_W-1:0] iv_count;
  logic        wr_ctrl, wr_stat, wr_ival;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ival = reg_wr && (reg_addr == ADDR_IVAL);

  etu_period_timer #(.EXP0(FIT_EXP0), .STEP(FIT_EXP_STEP)) u_fixed (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tb_tick),
    .hold   (1'b0),
    .sel    (ctrl_q[C_FX_PER_LO +: 2]),
    .expire (fx_exp)
  );

  etu_period_timer #(.EXP0(WDT_EXP0), .STEP(WDT_EXP_STEP)) u_wdog_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tb_tick),
    .hold   (wd_hold),
    .sel    (ctrl_q[C_WD_PER_LO +: 2]),
    .expire (wd_exp)
  );

  etu_interval_timer #(.W(PIT_W)) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tb_tick),
    .load       (wr_ival),
    .load_val   (reg_wdata[PIT_W-1:0]),
    .enable     (ctrl_q[C_IV_EN]),
    .autoreload (ctrl_q[C_IV_AUTO]),
    .expire     (iv_exp),
    .count      (iv_count)
  );

  etu_wdog_ctl u_wdog_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (wd_exp),
    .stage1     (stat_q[S_WD_FIRST]),
    .stage2     (stat_q[S_WD_SECOND]),
    .rst_kind   (ctrl_q[C_WD_KIND_LO +: 2]),
    .set_stage1 (wd_set1),
    .set_stage2 (wd_set2),
    .final_exp  (wd_final),
    .hold       (wd_hold),
    .rst_req    (wd_rst)
  );

  // Next state of control and status
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = reg_wdata & CTRL_MASK;
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_q & ~(reg_wdata & STAT_MASK);
    if (fx_exp)  stat_d[S_FX_EVT]    = 1'b1;
    if (iv_exp)  stat_d[S_IV_EVT]    = 1'b1;
    if (wd_set1) stat_d[S_WD_FIRST]  = 1'b1;
    if (wd_set2) stat_d[S_WD_SECOND] = 1'b1;
    if (wd_final) stat_d[S_WD_KIND_LO +: 2] = ctrl_q[C_WD_KIND_LO +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = stat_q;
      ADDR_IVAL: reg_rdata = 32'(iv_count);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_fixed    = stat_q[S_FX_EVT]    & ctrl_q[C_FX_IE];
  assign irq_interval = stat_q[S_IV_EVT]    & ctrl_q[C_IV_EN];
  assign irq_wdog     = stat_q[S_WD_SECOND] & ctrl_q[C_WD_IE];
  assign rst_core_req = wd_rst[0];
  assign rst_chip_req = wd_rst[1];
  assign rst_sys_req  = wd_rst[2];

  p_stage_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[S_WD_SECOND]) |-> $past(stat_q[S_WD_FIRST]));

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[S_FX_EVT] && !fx_exp) |=> !stat_q[S_FX_EVT]);

  p_kind_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sys_req |-> (stat_q[S_WD_KIND_LO +: 2] == 2'b11));
endmodule

// File: tb/etimer_unit_tb.sv
`timescale 1ns/1ps
module etimer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        b_tick, b_wr;
  logic [1:0]  b_addr;
  logic [31:0] b_wdata;
  logic [31:0] rdata;
  logic        irq_f, irq_i, irq_w, rc, rh, rs;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  etimer_unit #(.FIT_EXP0(2), .FIT_EXP_STEP(1), .WDT_EXP0(3), .WDT_EXP_STEP(1),
                .PIT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(b_tick), .reg_wr(b_wr),
    .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(rdata),
    .irq_fixed(irq_f), .irq_interval(irq_i), .irq_wdog(irq_w),
    .rst_core_req(rc), .rst_chip_req(rh), .rst_sys_req(rs));

  // Behavioural reference
  logic [31:0] m_ctrl, m_stat, m_pcnt, m_prel;
  int          m_fcnt, m_wcnt;
  bit          m_prun, m_hold;
  bit [2:0]    m_rst;

  always @(posedge clk) begin : model
    int fper, wper;
    bit fexp, wexp, pexp, pact, pload, fin;
    logic [31:0] ns, nc;
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; m_pcnt = 0; m_prel = 0;
      m_fcnt = 0; m_wcnt = 0; m_prun = 0; m_hold = 0; m_rst = 0;
    end else begin
      fper  = 1 << (2 + int'(m_ctrl[25:24]));
      wper  = 1 << (3 + int'(m_ctrl[31:30]));
      fexp  = b_tick && (m_fcnt >= fper - 1);
      wexp  = b_tick && !m_hold && (m_wcnt >= wper - 1);
      pload = b_wr && b_addr == 2'd2;
      pact  = m_prun && m_ctrl[26] && (m_prel > 1);
      pexp  = b_tick && pact && (m_pcnt == 1) && !pload;
      fin   = 0;
      ns = m_stat;
      if (b_wr && b_addr == 2'd1) ns = ns & ~(b_wdata & 32'hFC00_0000);
      if (fexp) ns[26] = 1;
      if (pexp) ns[27] = 1;
      if (wexp) begin
        if (!m_stat[31]) ns[31] = 1;
        else if (!m_stat[30]) ns[30] = 1;
        else begin ns[29:28] = m_ctrl[29:28]; fin = 1; end
      end
      m_rst = 3'b000;
      if (fin && m_ctrl[29:28] == 2'd1) m_rst = 3'b001;
      if (fin && m_ctrl[29:28] == 2'd2) m_rst = 3'b010;
      if (fin && m_ctrl[29:28] == 2'd3) m_rst = 3'b100;
      m_fcnt = fexp ? 0 : (b_tick ? m_fcnt + 1 : m_fcnt);
      m_wcnt = m_hold ? 0 : (wexp ? 0 : (b_tick ? m_wcnt + 1 : m_wcnt));
      m_hold = fin || (m_hold && m_stat[31] && m_stat[30]);
      if (pload) begin
        m_prel = b_wdata; m_pcnt = b_wdata; m_prun = (b_wdata > 1);
      end else if (b_tick && pact) begin
        if (m_pcnt == 1) begin
          if (m_ctrl[22]) m_pcnt = m_prel;
          else begin m_pcnt = 0; m_prun = 0; end
        end else m_pcnt = m_pcnt - 1;
      end
      nc = m_ctrl;
      if (b_wr && b_addr == 2'd0) nc = b_wdata & 32'hFFC0_0000;
      m_stat = ns;
      m_ctrl = nc;
    end
  end

  function automatic logic [31:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return m_stat;
      2'd2:    return m_pcnt;
      default: return 32'h0;
    endcase
  endfunction

  // Per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      bit bad;
      bad = 0;
      vectors++;
      if ({irq_f, irq_i, irq_w} !== {m_stat[26] & m_ctrl[23], m_stat[27] & m_ctrl[26],
                                     m_stat[30] & m_ctrl[27]}) begin
        bad = 1;
        $display("FAIL %s/R3 irq act=%b exp=%b", cur_req, {irq_f, irq_i, irq_w},
                 {m_stat[26] & m_ctrl[23], m_stat[27] & m_ctrl[26], m_stat[30] & m_ctrl[27]});
      end
      if ({rs, rh, rc} !== m_rst) begin
        bad = 1;
        $display("FAIL %s/R10 rst act=%b exp=%b", cur_req, {rs, rh, rc}, m_rst);
      end
      if (rdata !== m_rdata(b_addr)) begin
        bad = 1;
        $display("FAIL %s rdata@%0d act=%h exp=%h", cur_req, b_addr, rdata, m_rdata(b_addr));
      end
      if (bad) fails++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] a, input logic [31:0] d,
                       input logic t);
    @(negedge clk);
    b_wr = wr; b_addr = a; b_wdata = d; b_tick = t;
  endtask

  task automatic run_rand(input int n, input int tick_pct, input bit writes);
    for (int i = 0; i < n; i++) begin
      logic t;
      t = ($urandom_range(0, 99) < tick_pct);
      if (writes && $urandom_range(0, 9) == 0) begin
        case ($urandom_range(0, 3))
          0: drive(1, 2'd0, $urandom(), t);
          1: drive(1, 2'd1, $urandom(), t);
          2: drive(1, 2'd2, $urandom_range(0, 24), t);
          default: drive(1, 2'd3, $urandom(), t);
        endcase
      end else begin
        drive(0, 2'($urandom_range(0, 3)), 32'h0, t);
      end
    end
  endtask

  initial begin
    rst_n = 0; b_tick = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      b_addr = 2'(a); #1;
      chk(rdata == 0, "R1 reset read", rdata, 0);
    end
    chk({irq_f, irq_i, irq_w, rc, rh, rs} == 0, "R1 outputs",
        32'({irq_f, irq_i, irq_w, rc, rh, rs}), 0);

    // R11: control mask and unused address
    cur_req = "R11";
    b_wr = 1; b_addr = 0; b_wdata = 32'hFFFF_FFFF;
    @(negedge clk); b_wr = 0; #1;
    chk(rdata == 32'hFFC0_0000, "R11 ctrl mask", rdata, 32'hFFC0_0000);
    b_wr = 1; b_addr = 3; b_wdata = 32'hFFFF_FFFF;
    @(negedge clk); b_wr = 0; #1;
    chk(rdata == 0, "R11 addr3 read", rdata, 0);
    b_addr = 0; #1;
    chk(rdata == 32'hFFC0_0000, "R11 addr3 write ignored", rdata, 32'hFFC0_0000);

    // R5/R6: one-shot countdown of 5 ticks
    cur_req = "R5";
    drive(1, 2'd0, 32'h0400_0000, 0);
    drive(1, 2'd1, 32'hFC00_0000, 0);
    drive(1, 2'd2, 32'd5, 1);
    repeat (4) drive(0, 2'd1, 0, 1);
    @(negedge clk); #1;
    chk(rdata[27] == 1'b0, "R5 before expiry", 32'(rdata[27]), 0);
    b_tick = 1;
    @(negedge clk); #1;
    chk(rdata[27] == 1'b1, "R5 expiry on fifth tick", 32'(rdata[27]), 1);
    b_addr = 2; b_tick = 0; #1;
    chk(rdata == 0, "R6 one-shot stops at zero", rdata, 0);

    cur_req = "R6";
    drive(1, 2'd0, 32'h0440_0000, 1);
    drive(1, 2'd2, 32'd3, 1);
    run_rand(40, 100, 0);

    cur_req = "R7";
    drive(1, 2'd2, 32'd9, 1);
    run_rand(4, 100, 0);
    drive(1, 2'd0, 32'h0040_0000, 1);
    run_rand(10, 100, 0);
    drive(1, 2'd0, 32'h0440_0000, 1);
    run_rand(20, 100, 0);

    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      drive(1, 2'd0, 32'h0080_0000 | (32'(s) << 24), 1);
      run_rand(80, 100, 0);
      drive(1, 2'd1, 32'hFC00_0000, 1);
    end
    drive(1, 2'd0, 32'h0380_0000, 1);
    run_rand(20, 100, 0);
    drive(1, 2'd0, 32'h0080_0000, 1);
    run_rand(20, 60, 0);

    cur_req = "R3";
    drive(1, 2'd0, 32'h0C80_0000, 1);
    drive(1, 2'd2, 32'd4, 1);
    run_rand(60, 80, 0);
    drive(1, 2'd0, 32'h0000_0000, 1);
    run_rand(20, 80, 0);

    cur_req = "R4";
    for (int i = 0; i < 200; i++)
      drive(($urandom_range(0, 2) == 0), 2'd1, $urandom(), 1);

    cur_req = "R8";
    for (int w = 0; w < 4; w++) begin
      drive(1, 2'd0, 32'(w) << 30, 1);
      for (int i = 0; i < 150; i++)
        drive((i % 20) == 0, 2'd1, 32'hC000_0000, 1);
    end

    for (int k = 0; k < 4; k++) begin
      cur_req = (k == 0) ? "R9" : "R10";
      drive(1, 2'd0, 32'h0800_0000 | (32'(k) << 28), 1);
      drive(1, 2'd1, 32'hFC00_0000, 1);
      run_rand(120, 100, 0);
      drive(1, 2'd1, 32'h4000_0000, 1);
      run_rand(40, 70, 0);
    end

    cur_req = "R5";
    run_rand(4000, 70, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule